// File: doc/BRIEF.md
# Frame Sync Tracker

This block takes a serial bit stream, one bit for each cycle its valid strobe is high. It finds a repeating sync word, confirms it, and then follows it from frame to frame. The sync word, how many of its bits are compared, the frame length in bits and the number of consecutive misses that count as loss are all configuration inputs. They are held steady while the block runs.

The controller has hysteresis on both sides. A first match only makes the block suspect alignment. A second match exactly one frame later declares lock. After lock is declared, one missing word makes the block doubt lock while it still reports lock. Lock is given up only after a run of misses. Downstream logic uses the lock flag and a one-cycle frame-start pulse to slice the stream into frames.

Top module: `fsync_tracker`

## Requirements
- R1: After reset, `state_o` is 0 (hunting), `locked` is 0 and `frame_start` is 0. A reset applied while locked returns the block to this state.
- R2: In hunting (0), every valid bit position is tested. The newest bit is compared with `cfg_word[0]`, and the bit received `cfg_len-1` strobes earlier is compared with `cfg_word[cfg_len-1]`. The first full match moves the block to pattern check (1).
- R3: In pattern check (1), the block tests only the bit that arrives exactly `cfg_period` valid bits after the match. A match there moves it to locked (2). No match there returns it to hunting (0). A word shifted by even one bit is treated as absent.
- R4: In locked (2), only expected positions are tested. One miss moves the block to loss check (3), and `locked` stays 1.
- R5: In loss check (3), a match at the expected position returns the block to locked (2).
- R6: When `cfg_miss_lim` consecutive expected positions miss, the block goes to hunting (0) and `locked` falls. With a limit of 1, a single miss in locked (2) drops the block directly to hunting. A limit of 0 behaves as 1.
- R7: The miss count restarts at zero each time the block re-enters locked (2). A later loss again needs a full run of `cfg_miss_lim` misses.
- R8: `frame_start` is high for exactly one cycle, in the cycle after the last bit of a sync word that matches at an expected position while the block is in states 2 or 3. It stays low for the confirming match in state 1.
- R9: Only cycles with `bit_vld` high advance the shift window and the frame counter. Cycles with `bit_vld` low change no state, whatever `bit_in` carries. Expected positions are counted from the last accepted match or the last expected position.
- R10: `state_o` uses the encoding 0 = hunting, 1 = pattern check, 2 = locked, 3 = loss check. `locked` is 1 exactly in states 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial data bit |
| cfg_word | input | MAX_W | Sync word, bit 0 is the last bit received |
| cfg_len | input | LEN_W | Number of sync bits compared, 1..MAX_W |
| cfg_period | input | CNT_W | Frame length in valid bits, at least `cfg_len` |
| cfg_miss_lim | input | MISS_W | Consecutive misses that drop lock |
| locked | output | 1 | Lock indication (states 2 and 3) |
| state_o | output | 2 | Current controller state |
| frame_start | output | 1 | One-cycle pulse on each aligned sync word while locked |

## Verification
The hardest case to reach is a loss run that is broken by a single good word and then starts again. It shows whether the miss count really restarts, and it can only be reached through frame-accurate stimulus at the ports. The bench streams whole frames, each one a run of zero filler bits followed by the sync word or its bitwise inverse. A table of per-frame choices walks the block through lock, partial loss, recovery, a fresh run of misses and re-acquisition. Directed tests then cover a word displaced by one bit, strobe gaps that carry junk bits, limits of 1 and 0, and reset from lock.

// File: rtl/fsync_pkg.sv
// Shared types for the frame sync tracker.
package fsync_pkg;
    typedef enum logic [1:0] {
        ST_HUNT      = 2'd0,
        ST_CONF_PAT  = 2'd1,
        ST_LOCKED    = 2'd2,
        ST_CONF_LOSS = 2'd3
    } fsync_state_t;
endpackage

// File: rtl/fsync_matcher.sv
// Shift window over the serial stream and masked compare against the sync word.
// Assumes cfg_len <= MAX_W; a cfg_len of 0 never matches.
// hit is combinational and valid in the cycle that carries the final bit.
module fsync_matcher #(
    parameter int MAX_W = 16,
    parameter int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic [MAX_W-1:0] cfg_word,
    input  logic [LEN_W-1:0] cfg_len,
    output logic             hit
);
    logic [MAX_W-1:0] shreg_q;
    logic [MAX_W:0]   ext;
    logic [MAX_W-1:0] window;
    logic [MAX_W-1:0] mask;

    // Window includes the bit arriving this cycle as its newest bit.
    assign ext    = {shreg_q, bit_in};
    assign window = ext[MAX_W-1:0];

    // Compare only the low cfg_len positions.
    for (genvar i = 0; i < MAX_W; i++) begin : g_mask
        assign mask[i] = (LEN_W'(i) < cfg_len);
    end

    // Match decision for the current strobe.
    assign hit = bit_vld && (cfg_len != '0) &&
                 (((window ^ cfg_word) & mask) == '0);

    // Shift history on qualified bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg_q <= '0;
        else if (bit_vld)
            shreg_q <= window;
    end
endmodule

// File: rtl/fsync_period_ctr.sv
// Counts qualified bits since the last alignment point and flags the expected
// sync position. Assumes cfg_period >= 1.
module fsync_period_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             reload,
    input  logic [CNT_W-1:0] cfg_period,
    output logic             at_exp
);
    logic [CNT_W-1:0] cnt_q;

    // Current strobe is the cfg_period-th bit after the alignment point.
    assign at_exp = bit_vld && ((cnt_q + CNT_W'(1)) == cfg_period);

    // Restart on alignment points, otherwise advance per qualified bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (bit_vld)
            cnt_q <= reload ? '0 : cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/fsync_ctrl.sv
// Four-state acquisition controller with a consecutive-miss counter.
// Assumes hit and at_exp are already qualified by the bit strobe.
module fsync_ctrl
    import fsync_pkg::*;
#(
    parameter int MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              at_exp,
    input  logic [MISS_W-1:0] cfg_miss_lim,
    output fsync_state_t      state_q,
    output logic              frame_start_q
);
    fsync_state_t      state_d;
    logic [MISS_W-1:0] miss_q, miss_d, lim_eff, miss_inc;
    logic              fs_d;

    // Zero limit is handled as one.
    assign lim_eff  = (cfg_miss_lim == '0) ? MISS_W'(1) : cfg_miss_lim;
    assign miss_inc = miss_q + MISS_W'(1);

    // Next-state, miss-count and pulse decisions.
    always_comb begin
        state_d = state_q;
        miss_d  = miss_q;
        fs_d    = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (hit) state_d = ST_CONF_PAT;
            end
            ST_CONF_PAT: begin
                if (at_exp) begin
                    state_d = hit ? ST_LOCKED : ST_HUNT;
                    miss_d  = '0;
                end
            end
            ST_LOCKED, ST_CONF_LOSS: begin
                if (at_exp) begin
                    if (hit) begin
                        state_d = ST_LOCKED;
                        miss_d  = '0;
                        fs_d    = 1'b1;
                    end else if (miss_inc >= lim_eff) begin
                        state_d = ST_HUNT;
                        miss_d  = '0;
                    end else begin
                        state_d = ST_CONF_LOSS;
                        miss_d  = miss_inc;
                    end
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // State, miss count and frame pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_HUNT;
            miss_q        <= '0;
            frame_start_q <= 1'b0;
        end else begin
            state_q       <= state_d;
            miss_q        <= miss_d;
            frame_start_q <= fs_d;
        end
    end
endmodule

// File: rtl/fsync_tracker.sv
// Frame sync tracker top: matcher, period counter and controller.
// Assumes configuration inputs are static while running and cfg_period >= cfg_len.
module fsync_tracker
    import fsync_pkg::*;
#(
    parameter int MAX_W  = 16,
    parameter int CNT_W  = 16,
    parameter int MISS_W = 4,
    localparam int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic [MAX_W-1:0]  cfg_word,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [CNT_W-1:0]  cfg_period,
    input  logic [MISS_W-1:0] cfg_miss_lim,
    output logic              locked,
    output logic [1:0]        state_o,
    output logic              frame_start
);
    logic         hit, at_exp, reload;
    fsync_state_t state;

    fsync_matcher #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_match (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .cfg_word(cfg_word), .cfg_len(cfg_len), .hit(hit)
    );

    // Alignment points: every expected position, and a fresh match while hunting.
    assign reload = at_exp || ((state == ST_HUNT) && hit);

    fsync_period_ctr #(.CNT_W(CNT_W)) u_period (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .reload(reload),
        .cfg_period(cfg_period), .at_exp(at_exp)
    );

    fsync_ctrl #(.MISS_W(MISS_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .hit(hit), .at_exp(at_exp),
        .cfg_miss_lim(cfg_miss_lim), .state_q(state), .frame_start_q(frame_start)
    );

    // Outputs follow the registered state.
    assign state_o = state;
    assign locked  = (state == ST_LOCKED) || (state == ST_CONF_LOSS);
endmodule

// File: rtl/fsync_tracker_chk.sv
// Temporal checks on the tracker ports, attached by bind.
module fsync_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_vld,
    input logic       locked,
    input logic [1:0] state_o,
    input logic       frame_start
);
    // R9
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bit_vld)) |-> $stable(state_o));

    // R8
    pulse_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> locked);

    // R8
    pulse_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(bit_vld));

    // R2
    hunt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |=> (state_o inside {2'd0, 2'd1}));

    // R3
    conf_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1) |=> (state_o != 2'd3));

    // R4
    locked_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |=> (state_o != 2'd1));

    // R3
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(locked)) |-> ($past(state_o) == 2'd1));
endmodule

bind fsync_tracker fsync_tracker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .locked(locked),
    .state_o(state_o), .frame_start(frame_start)
);

// File: tb/fsync_tracker_tb.sv
// Frame-level bench: table walk, then directed corner cases.
module fsync_tracker_tb;
    localparam int MAX_W  = 16;
    localparam int CNT_W  = 16;
    localparam int MISS_W = 4;
    localparam int LEN_W  = $clog2(MAX_W + 1);
    localparam logic [7:0] SYNC = 8'hB7;
    localparam int GAP = 16;                 // filler bits; period = GAP + 8
    localparam int NVEC = 15;
    // {good word, expected frame_start, expected state}
    localparam logic [3:0] VEC [NVEC] = '{
        4'b1001, 4'b1010, 4'b1110, 4'b0011, 4'b1110,
        4'b0011, 4'b0011, 4'b1110, 4'b0011, 4'b0011,
        4'b0000, 4'b1001, 4'b0000, 4'b1001, 4'b1010
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bit_vld = 1'b0;
    logic              bit_in = 1'b0;
    logic [MAX_W-1:0]  cfg_word = MAX_W'(SYNC);
    logic [LEN_W-1:0]  cfg_len = LEN_W'(8);
    logic [CNT_W-1:0]  cfg_period = CNT_W'(GAP + 8);
    logic [MISS_W-1:0] cfg_miss_lim = MISS_W'(3);
    logic              locked, frame_start;
    logic [1:0]        state_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fsync_tracker #(.MAX_W(MAX_W), .CNT_W(CNT_W), .MISS_W(MISS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .cfg_word(cfg_word), .cfg_len(cfg_len), .cfg_period(cfg_period),
        .cfg_miss_lim(cfg_miss_lim), .locked(locked), .state_o(state_o),
        .frame_start(frame_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic b, input logic v);
        @(negedge clk);
        bit_vld = v;
        bit_in  = b;
        @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input logic good, input int gap);
        for (int i = 0; i < gap; i++) push(1'b0, 1'b1);
        for (int i = 7; i >= 0; i--) push(good ? SYNC[i] : ~SYNC[i], 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_vld = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 state", state_o, 0);
        chk("R1 locked", locked, 0);
        chk("R1 frame_start", frame_start, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int v = 0; v < NVEC; v++) begin
            send_frame(VEC[v][3], GAP);
            chk($sformatf("R4/R5/R6/R7 state frame %0d", v), state_o, int'(VEC[v][1:0]));
            chk($sformatf("R8 frame_start frame %0d", v), frame_start, int'(VEC[v][2]));
            chk($sformatf("R10 locked frame %0d", v), locked, int'(VEC[v][1]));
        end

        // R9: junk on unqualified cycles leaves state and alignment alone
        for (int i = 0; i < 10; i++) push(1'b0, 1'b1);
        for (int i = 0; i < 24; i++) push(SYNC[i % 8], 1'b0);
        chk("R9 state held", state_o, 2);
        for (int i = 0; i < GAP - 10; i++) push(1'b0, 1'b1);
        for (int i = 7; i >= 0; i--) push(SYNC[i], 1'b1);
        chk("R9 alignment kept", state_o, 2);
        chk("R9 frame_start aligned", frame_start, 1);
        push(1'b0, 1'b1);
        chk("R8 pulse one cycle", frame_start, 0);

        // R1: reset from lock
        do_reset();

        // R3: second word one bit late is treated as absent
        send_frame(1'b1, GAP);
        chk("R3 first match", state_o, 1);
        for (int i = 0; i < GAP + 1; i++) push(1'b0, 1'b1);
        for (int i = 7; i >= 1; i--) push(SYNC[i], 1'b1);
        chk("R3 shifted word rejected", state_o, 0);
        push(SYNC[0], 1'b1);
        chk("R2 rehunt match", state_o, 1);
        chk("R8 no pulse on confirm", frame_start, 0);

        // R6: limit 1 drops on the first miss
        do_reset();
        cfg_miss_lim = MISS_W'(1);
        send_frame(1'b1, GAP);
        send_frame(1'b1, GAP);
        chk("R6 lim1 locked", state_o, 2);
        send_frame(1'b0, GAP);
        chk("R6 lim1 drop", state_o, 0);
        chk("R6 lim1 locked low", locked, 0);

        // R6: limit 0 behaves as 1
        do_reset();
        cfg_miss_lim = MISS_W'(0);
        send_frame(1'b1, GAP);
        send_frame(1'b1, GAP);
        send_frame(1'b0, GAP);
        chk("R6 lim0 drop", state_o, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule